// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns each data-space access of a small 8-bit processor core into a physical target, a physical address and a read byte. The data space is divided into 32 banks of 128 bytes. Each bank has the same layout: a block of core registers, a block of special registers, a general RAM window and a common RAM window. The core registers and the common RAM are the same physical bytes in every bank. A direct access takes its bank from the bank-select core register and its 7-bit offset from the instruction. An indirect access uses one of two 16-bit pointers, each held in two core registers.

The top bit of the pointer high byte sends an indirect access to program memory. Program memory is read-only, returns the low byte of the addressed word, and needs an extra cycle. For that cycle the block raises a stall, and the core holds the access until the stall drops. The block contains the core registers, the general RAM of the implemented banks and the common RAM. Special registers stay outside the block, behind a read-data input and a write strobe.

Top module: `dm_mapper`

## Requirements
- R1: The 7-bit offset decodes to a region, reported on `tgt`. Offsets 0x00–0x0B are core registers (code 0), 0x0C–0x1F are special registers (code 1), 0x20–0x6F are general RAM (code 2) and 0x70–0x7F are common RAM (code 3). Program memory is code 4 and unimplemented is code 5.
- R2: The 12 core registers are the same storage in every bank, and their physical address equals the offset.
- R3: The common RAM (16 bytes) is shared by all banks, and its physical address is offset minus 0x70.
- R4: Each implemented bank (bank < GPR_BANKS, default 4) has its own 80 bytes of general RAM at physical address bank*80 + offset − 0x20.
- R5: General-RAM offsets in a bank at or above GPR_BANKS are unimplemented (code 5). They read 0x00, their physical address is 0, and writes to them have no effect.
- R6: A direct access takes its bank from bits 4:0 of the core register at offset 0x08, which resets to 0.
- R7: Pointer 0 is the core registers at offsets 0x04 (low) and 0x05 (high). Pointer 1 is at offsets 0x06 and 0x07, and `acc_psel` picks between them. When pointer bit 15 is clear, an indirect access uses bank = pointer bits 11:7 and offset = pointer bits 6:0.
- R8: When pointer bit 15 is set, an indirect access has code 4, `pm_addr` and `phys_addr` equal pointer bits 14:0, and a read returns the program-memory byte one cycle after the address is presented.
- R9: Indirect writes that target program memory change no storage and do not raise `sfr_we`.
- R10: An indirect program-memory read raises `stall` for exactly its first cycle. The data comes in the following cycle with `stall` low. Reset clears `stall`.
- R11: A special-register access returns `sfr_rdata`, raises `sfr_we` on a write, and has physical address bank*128 + offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_ind | input | 1 | 1 = indirect through a pointer, 0 = direct |
| acc_psel | input | 1 | Pointer choice for indirect accesses (0 or 1) |
| acc_off | input | 7 | In-bank offset for direct accesses |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write byte |
| sfr_rdata | input | 8 | Read byte from the special register addressed |
| pm_rdata | input | 8 | Low byte of the program word, one cycle after pm_addr |
| tgt | output | 3 | Target region code |
| phys_addr | output | 15 | Physical address within the target |
| rdata | output | 8 | Read byte |
| stall | output | 1 | Core must hold the access this cycle |
| sfr_we | output | 1 | Write strobe for the special registers |
| pm_addr | output | 15 | Program-memory read address |

## Verification
The hardest case to reach is an indirect program-memory access. It needs a pointer high byte with bit 7 set, and that byte can only be loaded through a prior direct write to a core register. The bench first writes pointer bytes whose low 15 bits also name a real general-RAM byte. It then holds a program read across two cycles to see the stall and the late data. It also issues a program write and reads the aliased RAM byte back to show nothing changed. Checking that core registers alias across banks likewise needs the bank-select register to be rewritten between the write and the read.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [2:0] {
    TG_CORE   = 3'd0,
    TG_SFR    = 3'd1,
    TG_GPR    = 3'd2,
    TG_COMMON = 3'd3,
    TG_PROG   = 3'd4,
    TG_NONE   = 3'd5
  } tgt_e;

  localparam int OFF_W   = 7;
  localparam int BANK_W  = 5;
  localparam int PTR_W   = 16;
  localparam int PA_W    = 15;
  localparam int DW      = 8;
  localparam int CORE_N  = 12;
  localparam int SFR_LO  = 12;
  localparam int GPR_LO  = 32;
  localparam int GPR_N   = 80;
  localparam int COM_LO  = 112;
  localparam int COM_N   = 16;
  localparam int BANK_SZ = 128;

  // Region from offset and bank; general RAM exists only in low banks
  function automatic tgt_e region(input logic [OFF_W-1:0] off,
                                  input logic [BANK_W-1:0] bank,
                                  input int gpr_banks);
    if (off < OFF_W'(SFR_LO))      return TG_CORE;
    else if (off < OFF_W'(GPR_LO)) return TG_SFR;
    else if (off < OFF_W'(COM_LO)) return (int'(bank) < gpr_banks) ? TG_GPR : TG_NONE;
    else                           return TG_COMMON;
  endfunction

  function automatic logic [PA_W-1:0] gpr_index(input logic [BANK_W-1:0] bank,
                                                input logic [OFF_W-1:0] off);
    return PA_W'(bank) * PA_W'(GPR_N) + PA_W'(off) - PA_W'(GPR_LO);
  endfunction
endpackage

// File: rtl/dm_route.sv
module dm_route
  import dm_pkg::*;
(
  input  logic              acc_ind,
  input  logic              acc_psel,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [BANK_W-1:0] bank_reg,
  input  logic [PTR_W-1:0]  ptr0,
  input  logic [PTR_W-1:0]  ptr1,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  off,
  output logic              to_prog,
  output logic [PA_W-1:0]   prog_addr
);
  logic [PTR_W-1:0] ptr;

  always_comb begin
    ptr       = acc_psel ? ptr1 : ptr0;
    to_prog   = acc_ind & ptr[PTR_W-1];
    prog_addr = ptr[PA_W-1:0];
    bank      = acc_ind ? ptr[OFF_W+BANK_W-1:OFF_W] : bank_reg;
    off       = acc_ind ? ptr[OFF_W-1:0] : acc_off;
  end
endmodule

// File: rtl/dm_decode.sv
module dm_decode
  import dm_pkg::*;
#(
  parameter int GPR_BANKS = 4
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  logic              to_prog,
  input  logic [PA_W-1:0]   prog_addr,
  output tgt_e              tgt,
  output logic [PA_W-1:0]   phys_addr
);
  always_comb begin
    if (to_prog) begin
      tgt       = TG_PROG;
      phys_addr = prog_addr;
    end else begin
      tgt = region(off, bank, GPR_BANKS);
      case (tgt)
        TG_CORE:   phys_addr = PA_W'(off);
        TG_SFR:    phys_addr = PA_W'(bank) * PA_W'(BANK_SZ) + PA_W'(off);
        TG_GPR:    phys_addr = gpr_index(bank, off);
        TG_COMMON: phys_addr = PA_W'(off) - PA_W'(COM_LO);
        default:   phys_addr = '0;
      endcase
    end
  end
endmodule

// File: rtl/dm_store.sv
module dm_store
  import dm_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  localparam int GPR_TOT = GPR_BANKS * GPR_N,
  localparam int GI_W    = $clog2(GPR_TOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tgt_e              tgt,
  input  logic [3:0]        off_lo,
  input  logic [GI_W-1:0]   gidx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     st_rdata,
  output logic [BANK_W-1:0] bank_reg,
  output logic [PTR_W-1:0]  ptr0,
  output logic [PTR_W-1:0]  ptr1
);
  logic [DW-1:0] core_q [CORE_N];
  logic [DW-1:0] gpr_q  [GPR_TOT];
  logic [DW-1:0] com_q  [COM_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CORE_N; i++) core_q[i] <= '0;
    end else if (wr_en && tgt == TG_CORE && int'(off_lo) < CORE_N) begin
      core_q[off_lo] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && tgt == TG_GPR)    gpr_q[gidx]  <= wdata;
    if (wr_en && tgt == TG_COMMON) com_q[off_lo] <= wdata;
  end

  always_comb begin
    case (tgt)
      TG_CORE:   st_rdata = (int'(off_lo) < CORE_N) ? core_q[off_lo] : '0;
      TG_GPR:    st_rdata = gpr_q[gidx];
      TG_COMMON: st_rdata = com_q[off_lo];
      default:   st_rdata = '0;
    endcase
    bank_reg = core_q[8][BANK_W-1:0];
    ptr0     = {core_q[5], core_q[4]};
    ptr1     = {core_q[7], core_q[6]};
  end
endmodule

// File: rtl/dm_mapper.sv
module dm_mapper
  import dm_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  localparam int GI_W = $clog2(GPR_BANKS * GPR_N)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_ind,
  input  logic        acc_psel,
  input  logic [6:0]  acc_off,
  input  logic        acc_we,
  input  logic [7:0]  acc_wdata,
  input  logic [7:0]  sfr_rdata,
  input  logic [7:0]  pm_rdata,
  output logic [2:0]  tgt,
  output logic [14:0] phys_addr,
  output logic [7:0]  rdata,
  output logic        stall,
  output logic        sfr_we,
  output logic [14:0] pm_addr
);
  logic [BANK_W-1:0] bank_reg, bank;
  logic [PTR_W-1:0]  ptr0, ptr1;
  logic [OFF_W-1:0]  off;
  logic              to_prog;
  logic [PA_W-1:0]   prog_addr;
  tgt_e              tgt_w;
  logic [DW-1:0]     st_rdata;
  logic              st_wr;     // event: storage write this cycle
  logic              pm_req;    // event: program read presented
  logic              pm_wait;   // second cycle of a program read

  dm_route u_route (
    .acc_ind, .acc_psel, .acc_off, .bank_reg, .ptr0, .ptr1,
    .bank, .off, .to_prog, .prog_addr
  );

  dm_decode #(.GPR_BANKS(GPR_BANKS)) u_decode (
    .bank, .off, .to_prog, .prog_addr, .tgt(tgt_w), .phys_addr
  );

  assign st_wr = acc_valid & acc_we &
                 (tgt_w == TG_CORE || tgt_w == TG_GPR || tgt_w == TG_COMMON);

  dm_store #(.GPR_BANKS(GPR_BANKS)) u_store (
    .clk, .rst_n, .wr_en(st_wr), .tgt(tgt_w), .off_lo(off[3:0]),
    .gidx(phys_addr[GI_W-1:0]), .wdata(acc_wdata),
    .st_rdata, .bank_reg, .ptr0, .ptr1
  );

  assign pm_req = acc_valid & ~acc_we & (tgt_w == TG_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pm_wait <= 1'b0;
    else        pm_wait <= pm_req & ~pm_wait;
  end

  always_comb begin
    stall   = pm_req & ~pm_wait;
    sfr_we  = acc_valid & acc_we & (tgt_w == TG_SFR);
    pm_addr = prog_addr;
    tgt     = tgt_w;
    case (tgt_w)
      TG_SFR:  rdata = sfr_rdata;
      TG_PROG: rdata = pm_rdata;
      TG_NONE: rdata = '0;
      default: rdata = st_rdata;
    endcase
  end

  // R10: stall never lasts two cycles in a row
  a_r10_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R10: stall only for a presented program read
  a_r10_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (acc_valid && !acc_we && tgt == 3'd4));
  // R9: program accesses never write storage or special registers
  a_r9_prog_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == 3'd4) |-> (!st_wr && !sfr_we));
  // R5: unimplemented locations read zero
  a_r5_unimp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == 3'd5) |-> (rdata == 8'h00 && phys_addr == '0));
  // R2: core register physical addresses stay below 12
  a_r2_core_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == 3'd0) |-> (phys_addr < 15'd12));
endmodule

// File: tb/test_dm_mapper.sv
module test_dm_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_ind = 1'b0, acc_psel = 1'b0, acc_we = 1'b0;
  logic [6:0]  acc_off = '0;
  logic [7:0]  acc_wdata = '0, sfr_rdata = '0, pm_rdata = '0;
  logic [2:0]  tgt;
  logic [14:0] phys_addr, pm_addr;
  logic [7:0]  rdata;
  logic        stall, sfr_we;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dm_mapper i_dm_mapper (.*);

  function automatic logic [7:0] pm_word(input logic [14:0] a);
    logic [14:0] v;
    v = a * 15'd7 + 15'd3;
    return v[7:0];
  endfunction

  always_ff @(posedge clk) pm_rdata <= pm_word(pm_addr);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ind, input logic psel, input logic [6:0] off, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_we = 1; acc_ind = ind; acc_psel = psel; acc_off = off; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 0; acc_we = 0;
  endtask

  task automatic rd(input logic ind, input logic psel, input logic [6:0] off);
    @(negedge clk);
    acc_valid = 1; acc_we = 0; acc_ind = ind; acc_psel = psel; acc_off = off;
    #1;
  endtask

  task automatic set_bank(input logic [7:0] b); wr(0, 0, 7'h08, b); endtask

  task automatic t_reset;
    chk("R10 stall after reset", stall, 0);
    rd(0, 0, 7'h08);
    chk("R6 bank reg reset", rdata, 0);
    chk("R1 core code", tgt, 0);
  endtask

  task automatic t_decode;
    rd(0, 0, 7'h0B); chk("R1 0x0B", tgt, 0);
    rd(0, 0, 7'h0C); chk("R1 0x0C", tgt, 1);
    rd(0, 0, 7'h1F); chk("R1 0x1F", tgt, 1);
    rd(0, 0, 7'h20); chk("R1 0x20", tgt, 2);
    rd(0, 0, 7'h6F); chk("R1 0x6F", tgt, 2);
    rd(0, 0, 7'h70); chk("R1 0x70", tgt, 3);
    rd(0, 0, 7'h7F); chk("R1 0x7F", tgt, 3);
  endtask

  task automatic t_core;
    set_bank(3);
    wr(0, 0, 7'h0A, 8'h5A);
    set_bank(7);
    rd(0, 0, 7'h0A);
    chk("R2 core alias data", rdata, 8'h5A);
    chk("R2 core phys", phys_addr, 8'h0A);
    rd(0, 0, 7'h08);
    chk("R6 bank reg read", rdata, 7);
  endtask

  task automatic t_common;
    set_bank(7);
    wr(0, 0, 7'h75, 8'hC3);
    set_bank(2);
    rd(0, 0, 7'h75);
    chk("R3 common alias", rdata, 8'hC3);
    chk("R3 common phys", phys_addr, 5);
  endtask

  task automatic t_gpr;
    set_bank(1); wr(0, 0, 7'h20, 8'h11);
    set_bank(2); wr(0, 0, 7'h20, 8'h22);
    set_bank(1); rd(0, 0, 7'h20);
    chk("R4 bank1 data", rdata, 8'h11);
    chk("R4 bank1 phys", phys_addr, 80);
    set_bank(2); rd(0, 0, 7'h20);
    chk("R4 bank2 data", rdata, 8'h22);
    chk("R4 bank2 phys", phys_addr, 160);
    set_bank(3); rd(0, 0, 7'h6F);
    chk("R4 last phys", phys_addr, 3 * 80 + 79);
  endtask

  task automatic t_unimp;
    set_bank(4); rd(0, 0, 7'h20);
    chk("R5 bank4 code", tgt, 5);
    set_bank(5);
    wr(0, 0, 7'h40, 8'hEE);
    rd(0, 0, 7'h40);
    chk("R5 unimp code", tgt, 5);
    chk("R5 unimp read zero", rdata, 0);
    chk("R5 unimp phys", phys_addr, 0);
  endtask

  task automatic t_sfr;
    set_bank(2);
    sfr_rdata = 8'h9C;
    rd(0, 0, 7'h15);
    chk("R11 sfr code", tgt, 1);
    chk("R11 sfr data", rdata, 8'h9C);
    chk("R11 sfr phys", phys_addr, 2 * 128 + 21);
    chk("R11 no strobe on read", sfr_we, 0);
    @(negedge clk); acc_we = 1; #1;
    chk("R11 strobe on write", sfr_we, 1);
    acc_valid = 0; acc_we = 0;
  endtask

  task automatic t_ind;
    wr(0, 0, 7'h04, 8'h20); wr(0, 0, 7'h05, 8'h01);   // ptr0 = 0x0120
    wr(0, 0, 7'h06, 8'hF5); wr(0, 0, 7'h07, 8'h00);   // ptr1 = 0x00F5
    set_bank(6);
    rd(1, 0, 7'h00);
    chk("R7 ptr0 data", rdata, 8'h22);
    chk("R7 ptr0 phys", phys_addr, 160);
    rd(1, 1, 7'h00);
    chk("R7 ptr1 common", rdata, 8'hC3);
    wr(0, 0, 7'h06, 8'hA0);                           // ptr1 = 0x00A0
    wr(1, 1, 7'h00, 8'h33);
    set_bank(1); rd(0, 0, 7'h20);
    chk("R7 ind write landed", rdata, 8'h33);
  endtask

  task automatic t_prog;
    wr(0, 0, 7'h04, 8'h23); wr(0, 0, 7'h05, 8'h81);   // ptr0 = 0x8123
    rd(1, 0, 7'h00);
    chk("R8 prog code", tgt, 4);
    chk("R8 pm addr", pm_addr, 15'h0123);
    chk("R8 phys addr", phys_addr, 15'h0123);
    chk("R10 stall first cycle", stall, 1);
    @(negedge clk); #1;
    chk("R10 stall cleared", stall, 0);
    chk("R8 prog data", rdata, pm_word(15'h0123));
    acc_valid = 0;
    @(negedge clk); #1;
    chk("R10 idle no stall", stall, 0);
  endtask

  task automatic t_prog_write;
    wr(0, 0, 7'h06, 8'hA0); wr(0, 0, 7'h07, 8'h80);   // ptr1 = 0x80A0
    @(negedge clk);
    acc_valid = 1; acc_we = 1; acc_ind = 1; acc_psel = 1; acc_wdata = 8'h99;
    #1;
    chk("R9 prog write code", tgt, 4);
    chk("R9 no sfr strobe", sfr_we, 0);
    chk("R10 no stall on write", stall, 0);
    @(posedge clk); #1;
    acc_valid = 0; acc_we = 0;
    set_bank(1); rd(0, 0, 7'h20);
    chk("R9 aliased ram unchanged", rdata, 8'h33);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_decode();
    t_core();
    t_common();
    t_gpr();
    t_unimp();
    t_sfr();
    t_ind();
    t_prog();
    t_prog_write();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule